// File: doc/BRIEF.md
# Block Transfer DMA Sequencer

This engine moves a block of bytes between a 16-bit host address space and a 19-bit expansion RAM. It can also exchange the two blocks or compare them. A neighbouring register block supplies the start addresses, the length and the per-command options. It reads back the engine's working counters and the completion pulses. Once started, the engine owns the host bus through a DMA request. It handles one byte per clock for copies and compares, and one byte per two clocks for an exchange. It freezes for as long as the bus-available input is low.

A transfer starts on a command pulse. It begins in the cycle after the command, or, when the command asks for a deferred start, in the cycle after the engine sees a host write to address 0xFF00. Both read ports return data in the same cycle that the address is driven, and writes take effect at the clock edge. The working counters keep their advanced values from one transfer to the next, unless the command asks for the bases to be restored when the transfer ends.

Top module: `bseq_engine`

## Requirements
- R1: After reset the working host address is 0x0000, the working expansion address is 0x00000 and the working length is 0xFFFF. DMA request, both write enables, eob_pulse and fault_pulse are low.
- R2: Type code 00 copies host bytes to the expansion RAM, and code 01 copies expansion bytes to the host. Each moves one byte per cycle, starting in the cycle after the command. dma_req is high for N+1 cycles, where N is the byte count.
- R3: Type code 10 exchanges the two blocks, taking two cycles per byte. The first cycle reads both sides, and the second writes both sides. dma_req is high for 2N+1 cycles.
- R4: Type code 11 compares the blocks one byte per cycle and never writes. On the first unequal byte it stops at once and pulses fault_pulse, not eob_pulse. Both addresses are then one past the failing byte, and the length has dropped by one for each byte compared.
- R5: A length of 0 moves 65536 bytes. When a transfer completes normally, the working length is 1.
- R6: Address-control code 00 advances both addresses and code 01 holds the expansion address. Code 10 holds the host address and code 11 holds both. A held address keeps its start value.
- R7: The host address wraps from 0xFFFF to 0x0000. The expansion address carries from bit 15 into bits 18:16.
- R8: With the defer option set, the engine waits, with dma_req low, for a snooped host write to exactly 0xFF00. In that cycle defer_clr pulses, and the transfer begins in the next cycle. Writes to other addresses have no effect.
- R9: While bus_avail is low during a transfer, no write enable is raised, the working counters hold, and dma_req stays high. The transfer resumes when bus_avail returns high.
- R10: eob_pulse (or fault_pulse) is high in the cycle after the final byte, and dma_req drops after that cycle. With the autoload option set, the working counters are restored to the bases at the end, including after a compare fault.
- R11: A cfg_load pulse while the engine is idle copies the three bases into the working counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_host_base | input | 16 | Host start address as last written |
| cfg_exp_base | input | 19 | Expansion start address as last written |
| cfg_len_base | input | 16 | Byte count as last written (0 means 65536) |
| cfg_load | input | 1 | Copy the bases into the working counters (idle only) |
| cmd_go | input | 1 | Execute pulse |
| cmd_type | input | 2 | Transfer type code |
| cmd_addr_ctl | input | 2 | Address hold code |
| cmd_autoload | input | 1 | Restore counters at the end |
| cmd_defer | input | 1 | Wait for a host write to 0xFF00 |
| snoop_we | input | 1 | Host write strobe seen on the bus |
| snoop_addr | input | 16 | Host write address seen on the bus |
| bus_avail | input | 1 | Low stalls the transfer |
| host_addr | output | 16 | Host bus address |
| host_rdata | input | 8 | Host bus read data |
| host_wdata | output | 8 | Host bus write data |
| host_we | output | 1 | Host bus write enable |
| dma_req | output | 1 | Host bus request |
| exp_addr | output | 19 | Expansion RAM address |
| exp_rdata | input | 8 | Expansion RAM read data |
| exp_wdata | output | 8 | Expansion RAM write data |
| exp_we | output | 1 | Expansion RAM write enable |
| cur_host | output | 16 | Working host address |
| cur_exp | output | 19 | Working expansion address |
| cur_len | output | 16 | Working length |
| defer_clr | output | 1 | Deferred-start option consumed |
| eob_pulse | output | 1 | Normal completion |
| fault_pulse | output | 1 | Compare mismatch |

## Verification
A bus-available stall can land on the very cycle that would finish the transfer. In that cycle the stall must win over both completion and the autoload restore. The bench provokes this by lowering bus_avail exactly on the last byte of a three-byte copy. It then holds bus_avail low for three cycles. During those cycles it checks that no write enable rises, that the working host address stays on the last byte, and that neither eob_pulse nor a drop of dma_req appears. After bus_avail returns, it checks that the final byte lands in memory and that eob_pulse follows one cycle later.

// File: rtl/bseq_pkg.sv
// Shared encodings for the block transfer sequencer.
// Assumes: the type codes are fixed by the command format the register block decodes.
package bseq_pkg;
    typedef enum logic [1:0] {
        XF_TO_EXP  = 2'b00,
        XF_TO_HOST = 2'b01,
        XF_SWAP    = 2'b10,
        XF_VERIFY  = 2'b11
    } xfer_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_SWAP2,
        ST_FIN
    } seq_state_e;
endpackage

// File: rtl/bseq_addr_ctr.sv
// Working address counter. It loads a base, or advances by one on a step unless it is held.
// Assumes: load has priority over step, so an end-of-transfer restore wins over the last advance.
module bseq_addr_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] base,
    input  logic         step,
    input  logic         hold,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Load, advance or keep the address.
    always_ff @(posedge clk) begin
        if (!rst_n)              q <= '0;
        else if (load)           q <= base;
        else if (step && !hold)  q <= q + ONE;
    end

    // R6
    held_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hold && !load) |=> $stable(q));
    // R7
    addr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hold && !load) |=> (q == $past(q) + ONE));
endmodule

// File: rtl/bseq_len_ctr.sv
// Working byte counter. It counts down per byte and stops at 1, which marks the last byte.
// Assumes: a value of 0 counts through 0xFFFF, so 0 means the full 65536 bytes.
module bseq_len_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] base,
    input  logic         step,
    output logic [W-1:0] q,
    output logic         last
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assign last = (q == ONE);

    // Load, or count down without going below 1.
    always_ff @(posedge clk) begin
        if (!rst_n)              q <= '1;
        else if (load)           q <= base;
        else if (step && !last)  q <= q - ONE;
    end

    // R5
    len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && !load) |=> (q == ONE));
    // R4
    len_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !load) |=> (q == $past(q) - ONE));
endmodule

// File: rtl/bseq_ctrl.sv
// Sequencer control. It handles start and deferred start, the swap phases, stalls and completion.
// Assumes: command fields are captured only when a go pulse arrives while idle.
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  logic [1:0] cmd_type,
    input  logic [1:0] cmd_addr_ctl,
    input  logic       cmd_autoload,
    input  logic       cmd_defer,
    input  logic       trig_hit,
    input  logic       bus_avail,
    input  logic       len_last,
    input  logic       mismatch,
    output seq_state_e state,
    output xfer_e      xfer,
    output logic [1:0] addr_ctl,
    output logic       step,
    output logic       restore,
    output logic       dma_req,
    output logic       defer_clr,
    output logic       eob,
    output logic       fault
);
    seq_state_e nxt;
    logic       auto_q;
    logic       end_now;
    logic       bad_cmp;

    assign bad_cmp   = (xfer == XF_VERIFY) && mismatch;
    assign step      = bus_avail && (((state == ST_RUN) && (xfer != XF_SWAP)) || (state == ST_SWAP2));
    assign end_now   = step && (len_last || bad_cmp);
    assign restore   = end_now && auto_q;
    assign dma_req   = (state == ST_RUN) || (state == ST_SWAP2) || (state == ST_FIN);
    assign defer_clr = (state == ST_ARMED) && trig_hit;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cmd_go) nxt = cmd_defer ? ST_ARMED : ST_RUN;
            ST_ARMED: if (trig_hit) nxt = ST_RUN;
            ST_RUN:   if (bus_avail) begin
                          if (xfer == XF_SWAP) nxt = ST_SWAP2;
                          else if (end_now)    nxt = ST_FIN;
                      end
            ST_SWAP2: if (bus_avail) nxt = end_now ? ST_FIN : ST_RUN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State, captured command and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            xfer     <= XF_TO_EXP;
            addr_ctl <= 2'b00;
            auto_q   <= 1'b0;
            eob      <= 1'b0;
            fault    <= 1'b0;
        end else begin
            state <= nxt;
            eob   <= end_now && !bad_cmp;
            fault <= end_now && bad_cmp;
            if ((state == ST_IDLE) && cmd_go) begin
                xfer     <= xfer_e'(cmd_type);
                addr_ctl <= cmd_addr_ctl;
                auto_q   <= cmd_autoload;
            end
        end
    end

    // R8
    armed_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ARMED) && !trig_hit) |=> (state == ST_ARMED));
    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && (state != ST_FIN) && !bus_avail) |=> $stable(state));
endmodule

// File: rtl/bseq_engine.sv
// Top of the block transfer sequencer. It holds the working counters, steers the data and
// keeps the swap holding byte.
// Assumes: both read ports return data in the cycle the address is driven, and writes land at the edge.
module bseq_engine
    import bseq_pkg::*;
#(
    parameter int              HOST_AW   = 16,
    parameter int              EXP_AW    = 19,
    parameter int              LEN_W     = 16,
    parameter int              DW        = 8,
    parameter logic [HOST_AW-1:0] TRIG_ADDR = 16'hFF00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] cfg_host_base,
    input  logic [EXP_AW-1:0]  cfg_exp_base,
    input  logic [LEN_W-1:0]   cfg_len_base,
    input  logic               cfg_load,
    input  logic               cmd_go,
    input  logic [1:0]         cmd_type,
    input  logic [1:0]         cmd_addr_ctl,
    input  logic               cmd_autoload,
    input  logic               cmd_defer,
    input  logic               snoop_we,
    input  logic [HOST_AW-1:0] snoop_addr,
    input  logic               bus_avail,
    output logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_rdata,
    output logic [DW-1:0]      host_wdata,
    output logic               host_we,
    output logic               dma_req,
    output logic [EXP_AW-1:0]  exp_addr,
    input  logic [DW-1:0]      exp_rdata,
    output logic [DW-1:0]      exp_wdata,
    output logic               exp_we,
    output logic [HOST_AW-1:0] cur_host,
    output logic [EXP_AW-1:0]  cur_exp,
    output logic [LEN_W-1:0]   cur_len,
    output logic               defer_clr,
    output logic               eob_pulse,
    output logic               fault_pulse
);
    seq_state_e      state;
    xfer_e           xfer;
    logic [1:0]      addr_ctl;
    logic            step;
    logic            restore;
    logic            len_last;
    logic            trig_hit;
    logic            mismatch;
    logic            load_all;
    logic            moving;
    logic [DW-1:0]   hold_q;

    assign trig_hit = snoop_we && (snoop_addr == TRIG_ADDR);
    assign mismatch = (host_rdata != exp_rdata);
    assign load_all = (cfg_load && (state == ST_IDLE)) || restore;

    bseq_ctrl u_ctrl (
        .clk, .rst_n, .cmd_go, .cmd_type, .cmd_addr_ctl, .cmd_autoload, .cmd_defer,
        .trig_hit, .bus_avail, .len_last, .mismatch,
        .state, .xfer, .addr_ctl, .step, .restore, .dma_req, .defer_clr,
        .eob(eob_pulse), .fault(fault_pulse)
    );

    bseq_addr_ctr #(.W(HOST_AW)) u_host_ctr (
        .clk, .rst_n, .load(load_all), .base(cfg_host_base),
        .step, .hold(addr_ctl[1]), .q(cur_host)
    );

    bseq_addr_ctr #(.W(EXP_AW)) u_exp_ctr (
        .clk, .rst_n, .load(load_all), .base(cfg_exp_base),
        .step, .hold(addr_ctl[0]), .q(cur_exp)
    );

    bseq_len_ctr #(.W(LEN_W)) u_len_ctr (
        .clk, .rst_n, .load(load_all), .base(cfg_len_base),
        .step, .q(cur_len), .last(len_last)
    );

    // Bus steering for the byte in progress.
    always_comb begin
        moving     = bus_avail && ((state == ST_RUN) || (state == ST_SWAP2));
        host_addr  = cur_host;
        exp_addr   = cur_exp;
        host_wdata = exp_rdata;
        exp_wdata  = (state == ST_SWAP2) ? hold_q : host_rdata;
        exp_we     = moving && (((state == ST_RUN) && (xfer == XF_TO_EXP)) || (state == ST_SWAP2));
        host_we    = moving && (((state == ST_RUN) && (xfer == XF_TO_HOST)) || (state == ST_SWAP2));
    end

    // Keep the host byte across the two swap phases.
    always_ff @(posedge clk) begin
        if (!rst_n)                                              hold_q <= '0;
        else if (bus_avail && (state == ST_RUN) && (xfer == XF_SWAP)) hold_q <= host_rdata;
    end

    // R9
    stall_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_avail |-> (!host_we && !exp_we));
    // R10
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(eob_pulse && fault_pulse));
    // R10
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eob_pulse || fault_pulse) |=> !dma_req);
    // R4
    verify_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && (xfer == XF_VERIFY)) |-> (!host_we && !exp_we));
endmodule

// File: tb/bseq_engine_tb.sv
`timescale 1ns/1ps
module bseq_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_host_base = '0;
    logic [18:0] cfg_exp_base = '0;
    logic [15:0] cfg_len_base = '0;
    logic        cfg_load = 1'b0;
    logic        cmd_go = 1'b0;
    logic [1:0]  cmd_type = '0;
    logic [1:0]  cmd_addr_ctl = '0;
    logic        cmd_autoload = 1'b0;
    logic        cmd_defer = 1'b0;
    logic        snoop_we = 1'b0;
    logic [15:0] snoop_addr = '0;
    logic        bus_avail = 1'b1;
    logic [15:0] host_addr;
    logic [7:0]  host_rdata, host_wdata, exp_rdata, exp_wdata;
    logic        host_we, exp_we, dma_req, defer_clr, eob_pulse, fault_pulse;
    logic [18:0] exp_addr, cur_exp;
    logic [15:0] cur_host, cur_len;

    logic [7:0]  hmem [256];
    logic [7:0]  emem [256];
    logic [7:0]  rh [256];
    logic [7:0]  re [256];
    logic        poke_en = 1'b0, poke_exp = 1'b0;
    logic [7:0]  poke_a = '0, poke_d = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bseq_engine u_dut (
        .clk, .rst_n, .cfg_host_base, .cfg_exp_base, .cfg_len_base, .cfg_load,
        .cmd_go, .cmd_type, .cmd_addr_ctl, .cmd_autoload, .cmd_defer,
        .snoop_we, .snoop_addr, .bus_avail,
        .host_addr, .host_rdata, .host_wdata, .host_we, .dma_req,
        .exp_addr, .exp_rdata, .exp_wdata, .exp_we,
        .cur_host, .cur_exp, .cur_len, .defer_clr, .eob_pulse, .fault_pulse
    );

    assign host_rdata = hmem[host_addr[7:0]];
    assign exp_rdata  = emem[exp_addr[7:0]];

    // Bus-side memories, filled with a pattern in reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                hmem[i] <= 8'(i * 3 + 1);
                emem[i] <= 8'(i * 5 + 128);
            end
        end else begin
            if (host_we) hmem[host_addr[7:0]] <= host_wdata;
            if (exp_we)  emem[exp_addr[7:0]]  <= exp_wdata;
            if (poke_en && !poke_exp) hmem[poke_a] <= poke_d;
            if (poke_en && poke_exp)  emem[poke_a] <= poke_d;
        end
    end

    typedef struct packed {
        logic [1:0]  ty;
        logic [1:0]  ctl;
        logic [15:0] h;
        logic [18:0] e;
        logic [15:0] len;
        logic [15:0] eh;
        logic [18:0] ee;
        logic [15:0] el;
        int          cyc;
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{2'b00, 2'b00, 16'h0010, 19'h00020, 16'd4, 16'h0014, 19'h00024, 16'd1, 5},
        '{2'b01, 2'b00, 16'h0040, 19'h00050, 16'd3, 16'h0043, 19'h00053, 16'd1, 4},
        '{2'b10, 2'b00, 16'h0080, 19'h00090, 16'd2, 16'h0082, 19'h00092, 16'd1, 5},
        '{2'b00, 2'b01, 16'h00A0, 19'h000B0, 16'd3, 16'h00A3, 19'h000B0, 16'd1, 4},
        '{2'b01, 2'b10, 16'h00C0, 19'h000D0, 16'd3, 16'h00C0, 19'h000D3, 16'd1, 4},
        '{2'b00, 2'b11, 16'h00E0, 19'h000E8, 16'd2, 16'h00E0, 19'h000E8, 16'd1, 3},
        '{2'b00, 2'b00, 16'hFFFE, 19'h0FFFF, 16'd3, 16'h0001, 19'h10002, 16'd1, 4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic sel_exp, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_exp = sel_exp; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic load_bases(input logic [15:0] h, input logic [18:0] e, input logic [15:0] n);
        @(negedge clk);
        cfg_host_base = h; cfg_exp_base = e; cfg_len_base = n; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic run(input logic [1:0] ty, input logic [1:0] ctl, input logic au,
                       output int ncyc, output int neob, output int nflt);
        @(negedge clk);
        cmd_type = ty; cmd_addr_ctl = ctl; cmd_autoload = au; cmd_defer = 1'b0; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        ncyc = 0; neob = 0; nflt = 0;
        forever begin
            if (dma_req) ncyc++;
            if (eob_pulse) neob++;
            if (fault_pulse) nflt++;
            if (!dma_req) break;
            @(negedge clk);
        end
    endtask

    // Reference model of the byte moves, on copies of the memories.
    task automatic model(input logic [1:0] ty, input logic [1:0] ctl,
                         input logic [15:0] h, input logic [18:0] e, input logic [15:0] n);
        logic [15:0] ha = h;
        logic [18:0] ea = e;
        logic [7:0]  t;
        int cnt = (n == 0) ? 65536 : int'(n);
        for (int i = 0; i < 256; i++) begin rh[i] = hmem[i]; re[i] = emem[i]; end
        for (int k = 0; k < cnt; k++) begin
            case (ty)
                2'b00: re[ea[7:0]] = rh[ha[7:0]];
                2'b01: rh[ha[7:0]] = re[ea[7:0]];
                2'b10: begin t = rh[ha[7:0]]; rh[ha[7:0]] = re[ea[7:0]]; re[ea[7:0]] = t; end
                default: ;
            endcase
            if (!ctl[1]) ha = ha + 16'd1;
            if (!ctl[0]) ea = ea + 19'd1;
        end
    endtask

    initial begin
        int nc, ne, nf, bad;
        string tag;
        logic [7:0] sv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(cur_host), 32'h0);
        chk("R1", 32'(cur_exp), 32'h0);
        chk("R1", 32'(cur_len), 32'hFFFF);
        chk("R1", {29'd0, dma_req, host_we, exp_we}, 32'h0);
        chk("R1", {30'd0, eob_pulse, fault_pulse}, 32'h0);

        // Vector table: copies, swap, address control, wrap and carry
        for (int i = 0; i < 7; i++) begin
            tag = (i == 2) ? "R3" : ((i >= 3 && i <= 5) ? "R6" : ((i == 6) ? "R7" : "R2"));
            load_bases(VEC[i].h, VEC[i].e, VEC[i].len);
            // R11 bases copied into the working counters
            chk("R11", 32'(cur_host), 32'(VEC[i].h));
            model(VEC[i].ty, VEC[i].ctl, VEC[i].h, VEC[i].e, VEC[i].len);
            run(VEC[i].ty, VEC[i].ctl, 1'b0, nc, ne, nf);
            chk(tag, 32'(cur_host), 32'(VEC[i].eh));
            chk(tag, 32'(cur_exp), 32'(VEC[i].ee));
            chk("R5", 32'(cur_len), 32'(VEC[i].el));
            chk(tag, 32'(nc), 32'(VEC[i].cyc));
            chk("R10", 32'(ne), 32'd1);
            bad = 0;
            for (int a = 0; a < 256; a++) if (hmem[a] !== rh[a] || emem[a] !== re[a]) bad++;
            chk(tag, 32'(bad), 32'd0);
        end

        // R4 compare with equal data
        for (int a = 16; a < 20; a++) poke(1'b1, 8'(a), hmem[a]);
        load_bases(16'h0010, 19'h00010, 16'd4);
        run(2'b11, 2'b00, 1'b0, nc, ne, nf);
        chk("R4", 32'(nc), 32'd5);
        chk("R4", {30'd0, ne[0], nf[0]}, 32'h2);
        chk("R4", 32'(cur_host), 32'h0014);

        // R4 compare stopping on the third byte
        for (int a = 32; a < 37; a++) poke(1'b1, 8'(a), hmem[a]);
        poke(1'b1, 8'h22, ~hmem[8'h22]);
        sv = emem[8'h22];
        load_bases(16'h0020, 19'h00020, 16'd5);
        run(2'b11, 2'b00, 1'b0, nc, ne, nf);
        chk("R4", 32'(nc), 32'd4);
        chk("R4", {30'd0, ne[0], nf[0]}, 32'h1);
        chk("R4", 32'(cur_host), 32'h0023);
        chk("R4", 32'(cur_exp), 32'h00023);
        chk("R4", 32'(cur_len), 32'd2);
        chk("R4", 32'(emem[8'h22]), 32'(sv));

        // R10 autoload after a normal copy
        load_bases(16'h0030, 19'h00040, 16'd2);
        run(2'b00, 2'b00, 1'b1, nc, ne, nf);
        chk("R10", 32'(cur_host), 32'h0030);
        chk("R10", 32'(cur_exp), 32'h00040);
        chk("R10", 32'(cur_len), 32'd2);
        chk("R10", 32'(emem[8'h41]), 32'(hmem[8'h31]));

        // R10 autoload after a compare fault loses the fault address
        poke(1'b1, 8'h50, ~hmem[8'h50]);
        load_bases(16'h0050, 19'h00050, 16'd3);
        run(2'b11, 2'b00, 1'b1, nc, ne, nf);
        chk("R10", 32'(nf), 32'd1);
        chk("R10", 32'(cur_host), 32'h0050);
        chk("R10", 32'(cur_len), 32'd3);

        // R8 deferred start
        load_bases(16'h0060, 19'h00060, 16'd2);
        @(negedge clk);
        cmd_type = 2'b00; cmd_addr_ctl = 2'b00; cmd_autoload = 1'b0; cmd_defer = 1'b1; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0; cmd_defer = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", {31'd0, dma_req}, 32'h0);
        snoop_we = 1'b1; snoop_addr = 16'hFF01;
        #1 chk("R8", {31'd0, defer_clr}, 32'h0);
        @(negedge clk);
        chk("R8", {31'd0, dma_req}, 32'h0);
        chk("R8", 32'(cur_host), 32'h0060);
        snoop_addr = 16'hFF00;
        #1 chk("R8", {31'd0, defer_clr}, 32'h1);
        @(negedge clk);
        snoop_we = 1'b0;
        chk("R8", {31'd0, dma_req}, 32'h1);
        while (dma_req) @(negedge clk);
        chk("R8", 32'(cur_host), 32'h0062);

        // R9 stall landing on the last byte
        load_bases(16'h0070, 19'h00070, 16'd3);
        @(negedge clk);
        cmd_type = 2'b00; cmd_addr_ctl = 2'b00; cmd_autoload = 1'b0; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_avail = 1'b0;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            chk("R9", {29'd0, host_we, exp_we, eob_pulse}, 32'h0);
            chk("R9", {31'd0, dma_req}, 32'h1);
            chk("R9", 32'(cur_host), 32'h0072);
        end
        bus_avail = 1'b1;
        @(negedge clk);
        chk("R9", {31'd0, eob_pulse}, 32'h1);
        chk("R9", 32'(cur_host), 32'h0073);
        chk("R9", 32'(emem[8'h72]), 32'(hmem[8'h72]));
        @(negedge clk);
        chk("R10", {31'd0, dma_req}, 32'h0);

        // R5 length zero moves 65536 bytes
        load_bases(16'h0090, 19'h00090, 16'd0);
        run(2'b00, 2'b11, 1'b0, nc, ne, nf);
        chk("R5", 32'(nc), 32'd65537);
        chk("R5", 32'(cur_len), 32'd1);
        chk("R5", 32'(cur_host), 32'h0090);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule